// File: doc/BRIEF.md
# Receive Packet FIFO Controller

This block buffers received packets between a MAC-side writer and a host-side reader. Payload arrives as 32-bit words in a data FIFO, with a marker on the final word of each packet. Each packet also has one status word, which goes into a separate status FIFO. The host reads both FIFOs through show-ahead ports: the head word is always visible, and a pop request removes it.

Two self-clearing control operations act on the buffers. A skip request discards whatever is left of the packet at the head of the data FIFO. The read pointer then moves in steps of up to four words per clock until it reaches the first word of the following packet. A flush request empties both FIFOs in one operation, but only while the receiver reports that it is halted. A request that breaks its precondition is dropped and sets a sticky error flag.

The controller keeps a small side queue of packet lengths, one entry for each completed packet. Together with a count of the words already taken from the head packet, this gives the skip distance.

Top module: `rx_pkt_fifo_ctrl`

## Requirements
- R1: The data FIFO returns accepted words in arrival order. `data_count`, `data_empty` and `data_full` follow every accepted push and pop. A push while full is dropped.
- R2: The status FIFO holds one word per accepted status push, independently of the data FIFO. It reports its own count, empty and full, and a push while full is dropped.
- R3: A legal skip leaves the first word of the next packet at the data head. It removes exactly the remaining words of the old head packet, and the status FIFO keeps its count and head word.
- R4: A legal skip keeps `ffwd_busy` high for ceil(remaining/4) cycles, starting the cycle after the request. The bit then clears by itself, and the data count never falls by more than 4 in one cycle.
- R5: A skip request is illegal when the head packet is incomplete (its last word has not arrived) or fewer than 4 of its words remain. An illegal request changes no FIFO state, does not raise `ffwd_busy`, and sets `ctrl_err`.
- R6: While a skip is busy, data and status pops are ignored. Data and status pushes are still accepted.
- R7: A flush request with `rx_halted` high raises `dump_busy` for exactly one cycle. After that cycle both FIFOs are empty with zero counts.
- R8: A flush request with `rx_halted` low is ignored: counts and contents stay unchanged, `dump_busy` stays low, and `ctrl_err` is set.
- R9: `stat_hold` is high during either operation and for 2 further cycles after it ends. A status pop while `stat_hold` is high has no effect.
- R10: `ctrl_err` stays set until `err_clr` is asserted, and an error event in the same cycle as `err_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_valid | input | 1 | Push a data word |
| wr_data | input | 32 | Data word to push |
| wr_data_last | input | 1 | Pushed word ends its packet |
| wr_stat_valid | input | 1 | Push a status word |
| wr_stat | input | 32 | Status word to push |
| rd_data_pop | input | 1 | Remove the head data word |
| rd_data | output | 32 | Head data word (show-ahead) |
| data_count | output | 5 | Words in the data FIFO |
| data_empty | output | 1 | Data FIFO empty |
| data_full | output | 1 | Data FIFO full |
| rd_stat_pop | input | 1 | Remove the head status word |
| rd_stat | output | 32 | Head status word (show-ahead) |
| stat_count | output | 3 | Words in the status FIFO |
| stat_empty | output | 1 | Status FIFO empty |
| stat_full | output | 1 | Status FIFO full |
| ffwd_set | input | 1 | Request a skip of the head packet |
| dump_set | input | 1 | Request a flush of both FIFOs |
| rx_halted | input | 1 | Receiver halted, flush permitted |
| err_clr | input | 1 | Clear the sticky error flag |
| ffwd_busy | output | 1 | Skip in progress (self-clearing) |
| dump_busy | output | 1 | Flush in progress (self-clearing) |
| stat_hold | output | 1 | Status pops currently blocked |
| ctrl_err | output | 1 | Sticky illegal-request flag |

## Verification
The skip operation is swept over every head-packet length from 1 to 8 and every count of words popped beforehand, from none to all of them. The sweep crosses the 4-word legality threshold and hits both exact and partial multiples of the 4-word step, which separates off-by-one errors in the remaining-word arithmetic from errors in step sizing. Separate patterns issue a skip on a packet whose last word has not arrived, and a skip while pushes and pop requests arrive at the same time. This distinguishes blocked pops from lost pushes. Flush is tried both with and without the halt input, and fill-to-full runs confirm that overflow pushes are dropped.

// File: rtl/rpf_pkg.sv
// Shared types for the receive packet FIFO controller.
package rpf_pkg;
    // Operation currently owning the read side.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_SKIP = 2'd1,
        OP_FLUSH = 2'd2
    } op_e;
endpackage

// File: rtl/rpf_ring.sv
// Circular FIFO with a show-ahead head word and a multi-word read advance.
// Assumes DEPTH is a power of two and that adv never exceeds the current count.
// A flush returns both pointers and the count to their reset values.
module rpf_ring #(
    parameter int W = 32,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic [CW-1:0] adv,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;

    // Accept a push only when space exists and no flush is pending.
    always_comb begin
        push_ok = push && !full && !flush;
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        head    = mem[rptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + AW'(1);
            rptr  <= rptr + AW'(adv);
            count <= count + CW'(push_ok) - adv;
        end
    end
endmodule

// File: rtl/rpf_len_track.sv
// Counts the words of the packet being written and emits its length when the
// final word is accepted, feeding the packet-length side queue.
// Assumes push_ok is already qualified against the data FIFO being full.
module rpf_len_track #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          last,
    output logic          len_push,
    output logic [LW-1:0] len_val
);
    logic [LW-1:0] in_len;

    // Length of the packet including the word being pushed now.
    always_comb begin
        len_val  = in_len + LW'(1);
        len_push = push_ok && last && !flush;
    end

    // Running word count for the packet under construction.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) in_len <= '0;
        else if (push_ok) in_len <= last ? '0 : len_val;
    end
endmodule

// File: rtl/rpf_ctrl.sv
// Read-side controller: qualifies host pops, runs the skip and flush
// operations, tracks the offset into the head packet, the settling guard and
// the sticky error flag. Assumes len_head is valid whenever len_empty is low.
module rpf_ctrl
    import rpf_pkg::*;
#(
    parameter int LW = 5,
    parameter int FFWD_MIN = 4,
    parameter int SKIP_STEP = 4,
    parameter int GUARD_CYC = 2,
    localparam int GW = $clog2(GUARD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ffwd_set,
    input  logic          dump_set,
    input  logic          rx_halted,
    input  logic          err_clr,
    input  logic          data_pop,
    input  logic          stat_pop,
    input  logic          data_empty,
    input  logic          stat_empty,
    input  logic          len_empty,
    input  logic [LW-1:0] len_head,
    output logic [LW-1:0] data_adv,
    output logic          stat_adv,
    output logic          len_pop,
    output logic          flush,
    output logic          ffwd_busy,
    output logic          dump_busy,
    output logic          stat_hold,
    output logic          ctrl_err
);
    localparam logic [LW-1:0] MIN_L  = LW'(FFWD_MIN);
    localparam logic [LW-1:0] STEP_L = LW'(SKIP_STEP);
    localparam logic [GW-1:0] GUARD_L = GW'(GUARD_CYC);

    op_e           state;
    logic [LW-1:0] rd_off;
    logic [LW-1:0] rem;
    logic [LW-1:0] step;
    logic [GW-1:0] guard;
    logic          idle, skip_go, skip_bad, flush_go, flush_bad;
    logic          data_pop_ok, skip_done, pop_ends_pkt;

    // Request qualification, skip step sizing and pop gating.
    always_comb begin
        idle         = (state == OP_IDLE);
        rem          = len_head - rd_off;
        step         = (rem > STEP_L) ? STEP_L : rem;
        skip_go      = idle && ffwd_set && !len_empty && (rem >= MIN_L);
        skip_bad     = idle && ffwd_set && !(!len_empty && (rem >= MIN_L));
        flush_go     = idle && !ffwd_set && dump_set && rx_halted;
        flush_bad    = idle && !ffwd_set && dump_set && !rx_halted;
        data_pop_ok  = idle && !ffwd_set && data_pop && !data_empty;
        stat_hold    = !idle || (guard != '0);
        stat_adv     = !stat_hold && stat_pop && !stat_empty;
        skip_done    = (state == OP_SKIP) && (step == rem);
        pop_ends_pkt = data_pop_ok && !len_empty && (rd_off + LW'(1) == len_head);
        len_pop      = skip_done || pop_ends_pkt;
        data_adv     = (state == OP_SKIP) ? step : LW'(data_pop_ok);
        flush        = (state == OP_FLUSH);
        ffwd_busy    = (state == OP_SKIP);
        dump_busy    = (state == OP_FLUSH);
    end

    // Operation sequencing and settling guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OP_IDLE;
            guard <= '0;
        end else begin
            if (guard != '0) guard <= guard - GW'(1);
            case (state)
                OP_IDLE: begin
                    if (skip_go) state <= OP_SKIP;
                    else if (flush_go) state <= OP_FLUSH;
                end
                OP_SKIP: begin
                    if (skip_done) begin
                        state <= OP_IDLE;
                        guard <= GUARD_L;
                    end
                end
                OP_FLUSH: begin
                    state <= OP_IDLE;
                    guard <= GUARD_L;
                end
                default: state <= OP_IDLE;
            endcase
        end
    end

    // Offset of the read pointer inside the head packet.
    always_ff @(posedge clk) begin
        if (!rst_n || flush || len_pop) rd_off <= '0;
        else rd_off <= rd_off + data_adv;
    end

    // Sticky error flag; a new error beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_err <= 1'b0;
        else if (skip_bad || flush_bad) ctrl_err <= 1'b1;
        else if (err_clr) ctrl_err <= 1'b0;
    end
endmodule

// File: rtl/rx_pkt_fifo_ctrl.sv
// Top level: data FIFO, status FIFO, packet-length side queue, length tracker
// and read-side controller. Assumes both depths are powers of two; the length
// queue is as deep as the data FIFO so it can never overflow.
module rx_pkt_fifo_ctrl #(
    parameter int DATA_W = 32,
    parameter int DATA_DEPTH = 16,
    parameter int STAT_DEPTH = 4,
    parameter int FFWD_MIN = 4,
    parameter int SKIP_STEP = 4,
    parameter int GUARD_CYC = 2,
    localparam int DCW = $clog2(DATA_DEPTH) + 1,
    localparam int SCW = $clog2(STAT_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_data_last,
    input  logic              wr_stat_valid,
    input  logic [DATA_W-1:0] wr_stat,
    input  logic              rd_data_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [DCW-1:0]    data_count,
    output logic              data_empty,
    output logic              data_full,
    input  logic              rd_stat_pop,
    output logic [DATA_W-1:0] rd_stat,
    output logic [SCW-1:0]    stat_count,
    output logic              stat_empty,
    output logic              stat_full,
    input  logic              ffwd_set,
    input  logic              dump_set,
    input  logic              rx_halted,
    input  logic              err_clr,
    output logic              ffwd_busy,
    output logic              dump_busy,
    output logic              stat_hold,
    output logic              ctrl_err
);
    logic           flush;
    logic           data_push_ok;
    logic           stat_push_ok;
    logic [DCW-1:0] data_adv;
    logic           stat_adv;
    logic           len_push, len_pop, len_empty, len_full;
    logic [DCW-1:0] len_val, len_head, len_count;

    // Write-side qualification.
    always_comb begin
        data_push_ok = wr_data_valid && !data_full && !dump_busy;
        stat_push_ok = wr_stat_valid && !stat_full && !dump_busy;
    end

    rpf_ring #(.W(DATA_W), .DEPTH(DATA_DEPTH)) u_data_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(data_push_ok),
        .wdata(wr_data), .adv(data_adv), .head(rd_data),
        .count(data_count), .empty(data_empty), .full(data_full)
    );

    rpf_ring #(.W(DATA_W), .DEPTH(STAT_DEPTH)) u_stat_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(stat_push_ok),
        .wdata(wr_stat), .adv(SCW'(stat_adv)), .head(rd_stat),
        .count(stat_count), .empty(stat_empty), .full(stat_full)
    );

    rpf_ring #(.W(DCW), .DEPTH(DATA_DEPTH)) u_len_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(len_push),
        .wdata(len_val), .adv(DCW'(len_pop)), .head(len_head),
        .count(len_count), .empty(len_empty), .full(len_full)
    );

    rpf_len_track #(.LW(DCW)) u_len_track (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_ok(data_push_ok),
        .last(wr_data_last), .len_push(len_push), .len_val(len_val)
    );

    rpf_ctrl #(
        .LW(DCW), .FFWD_MIN(FFWD_MIN), .SKIP_STEP(SKIP_STEP), .GUARD_CYC(GUARD_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ffwd_set(ffwd_set), .dump_set(dump_set),
        .rx_halted(rx_halted), .err_clr(err_clr), .data_pop(rd_data_pop),
        .stat_pop(rd_stat_pop), .data_empty(data_empty), .stat_empty(stat_empty),
        .len_empty(len_empty), .len_head(len_head), .data_adv(data_adv),
        .stat_adv(stat_adv), .len_pop(len_pop), .flush(flush),
        .ffwd_busy(ffwd_busy), .dump_busy(dump_busy), .stat_hold(stat_hold),
        .ctrl_err(ctrl_err)
    );
endmodule

// File: rtl/rpf_chk.sv
// Property checker for rx_pkt_fifo_ctrl, attached through bind.
module rpf_chk #(
    parameter int DATA_DEPTH = 16,
    parameter int DCW = 5,
    parameter int SCW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ffwd_set,
    input logic           dump_set,
    input logic           rx_halted,
    input logic           err_clr,
    input logic [DCW-1:0] data_count,
    input logic [SCW-1:0] stat_count,
    input logic           ffwd_busy,
    input logic           dump_busy,
    input logic           stat_hold,
    input logic           ctrl_err
);
    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(data_count) <= DATA_DEPTH);
    // R3
    skip_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ffwd_busy |=> int'(stat_count) >= int'($past(stat_count)));
    // R4
    skip_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ffwd_busy |=> int'(data_count) + 4 >= int'($past(data_count)));
    // R6
    skip_blocks_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ffwd_busy |-> stat_hold);
    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dump_busy |=> (data_count == '0) && (stat_count == '0) && !dump_busy);
    // R8
    flush_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dump_set && !rx_halted && !ffwd_set && !ffwd_busy && !dump_busy)
        |=> !dump_busy && ctrl_err);
    // R9
    guard_after_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ffwd_busy) || $fell(dump_busy)) |-> stat_hold);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_err && !err_clr) |=> ctrl_err);
endmodule

bind rx_pkt_fifo_ctrl rpf_chk #(.DATA_DEPTH(DATA_DEPTH), .DCW(DCW), .SCW(SCW)) u_rpf_chk (
    .clk(clk), .rst_n(rst_n), .ffwd_set(ffwd_set), .dump_set(dump_set),
    .rx_halted(rx_halted), .err_clr(err_clr), .data_count(data_count),
    .stat_count(stat_count), .ffwd_busy(ffwd_busy), .dump_busy(dump_busy),
    .stat_hold(stat_hold), .ctrl_err(ctrl_err)
);

// File: tb/test_rx_pkt_fifo_ctrl.sv
module test_rx_pkt_fifo_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_data_valid = 1'b0, wr_data_last = 1'b0, wr_stat_valid = 1'b0;
    logic [31:0] wr_data = '0, wr_stat = '0;
    logic        rd_data_pop = 1'b0, rd_stat_pop = 1'b0;
    logic        ffwd_set = 1'b0, dump_set = 1'b0, rx_halted = 1'b0, err_clr = 1'b0;
    logic [31:0] rd_data, rd_stat;
    logic [4:0]  data_count;
    logic [2:0]  stat_count;
    logic        data_empty, data_full, stat_empty, stat_full;
    logic        ffwd_busy, dump_busy, stat_hold, ctrl_err;
    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    rx_pkt_fifo_ctrl i_rx_pkt_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_data_valid(wr_data_valid), .wr_data(wr_data),
        .wr_data_last(wr_data_last), .wr_stat_valid(wr_stat_valid), .wr_stat(wr_stat),
        .rd_data_pop(rd_data_pop), .rd_data(rd_data), .data_count(data_count),
        .data_empty(data_empty), .data_full(data_full), .rd_stat_pop(rd_stat_pop),
        .rd_stat(rd_stat), .stat_count(stat_count), .stat_empty(stat_empty),
        .stat_full(stat_full), .ffwd_set(ffwd_set), .dump_set(dump_set),
        .rx_halted(rx_halted), .err_clr(err_clr), .ffwd_busy(ffwd_busy),
        .dump_busy(dump_busy), .stat_hold(stat_hold), .ctrl_err(ctrl_err)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_pkt(int len, int base, int stat);
        for (int i = 0; i < len; i++) begin
            wr_data_valid = 1'b1; wr_data = base + i; wr_data_last = (i == len - 1);
            cyc();
        end
        wr_data_valid = 1'b0; wr_data_last = 1'b0;
        wr_stat_valid = 1'b1; wr_stat = stat;
        cyc();
        wr_stat_valid = 1'b0;
    endtask

    task automatic pop_data();
        rd_data_pop = 1'b1; cyc(); rd_data_pop = 1'b0;
    endtask

    task automatic clear_err();
        err_clr = 1'b1; cyc(); err_clr = 1'b0;
    endtask

    // Legal flush used as cleanup; checks the flush rules every time.
    task automatic do_flush();
        rx_halted = 1'b1; dump_set = 1'b1; cyc(); dump_set = 1'b0;
        chk("R7 dump_busy raised", dump_busy, 1);
        cyc();
        chk("R7 dump_busy cleared", dump_busy, 0);
        chk("R7 data_count after flush", data_count, 0);
        chk("R7 stat_count after flush", stat_count, 0);
        chk("R7 data_empty after flush", data_empty, 1);
        chk("R9 stat_hold after flush", stat_hold, 1);
        rx_halted = 1'b0;
        cyc(); cyc();
        chk("R9 stat_hold released", stat_hold, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // Reset state (R1, R2, R10)
        chk("R1 reset data_empty", data_empty, 1);
        chk("R1 reset data_count", data_count, 0);
        chk("R2 reset stat_empty", stat_empty, 1);
        chk("R4 reset ffwd_busy", ffwd_busy, 0);
        chk("R10 reset ctrl_err", ctrl_err, 0);
        chk("R9 reset stat_hold", stat_hold, 0);

        // Sweep of head length and words popped before the skip request.
        for (int len = 1; len <= 8; len++) begin
            for (int p = 0; p <= len; p++) begin
                int base_a, base_b, sa, sb, rem;
                base_a = (len << 12) | (p << 8);
                base_b = 32'h000B_0000 | (len << 8) | (p << 4);
                sa = 32'h5A00 + len * 16 + p;
                sb = 32'h5B00 + len * 16 + p;
                push_pkt(len, base_a, sa);
                push_pkt(3, base_b, sb);
                chk("R1 count after pushes", data_count, len + 3);
                chk("R2 status count after pushes", stat_count, 2);
                for (int i = 0; i < p; i++) begin
                    chk("R1 pop order", rd_data, base_a + i);
                    pop_data();
                end
                rem = (p == len) ? 3 : len - p;
                ffwd_set = 1'b1; cyc(); ffwd_set = 1'b0;
                if (rem >= 4) begin
                    n = 0;
                    while (ffwd_busy && n < 20) begin n++; cyc(); end
                    chk("R4 skip busy cycles", n, (rem + 3) / 4);
                    chk("R3 head after skip", rd_data, base_b);
                    chk("R3 data_count after skip", data_count, 3);
                    chk("R3 stat_count after skip", stat_count, 2);
                    chk("R5 no error on legal skip", ctrl_err, 0);
                    chk("R9 guard after skip", stat_hold, 1);
                    rd_stat_pop = 1'b1; cyc(); rd_stat_pop = 1'b0;
                    chk("R9 pop during guard ignored", stat_count, 2);
                    cyc();
                    chk("R9 guard over", stat_hold, 0);
                    chk("R3 status head kept", rd_stat, sa);
                    rd_stat_pop = 1'b1; cyc(); rd_stat_pop = 1'b0;
                    chk("R2 status pop", stat_count, 1);
                    chk("R2 status order", rd_stat, sb);
                end else begin
                    chk("R5 illegal skip not busy", ffwd_busy, 0);
                    chk("R5 illegal skip error", ctrl_err, 1);
                    chk("R5 illegal skip count", data_count, len + 3 - p);
                    chk("R5 illegal skip head", rd_data, (p == len) ? base_b : base_a + p);
                    cyc();
                    chk("R10 error sticky", ctrl_err, 1);
                    clear_err();
                    chk("R10 error cleared", ctrl_err, 0);
                end
                do_flush();
            end
        end

        // Skip on an incomplete head packet is illegal (R5).
        for (int i = 0; i < 6; i++) begin
            wr_data_valid = 1'b1; wr_data = 32'h700 + i; cyc();
        end
        wr_data_valid = 1'b0;
        ffwd_set = 1'b1; cyc(); ffwd_set = 1'b0;
        chk("R5 incomplete skip not busy", ffwd_busy, 0);
        chk("R5 incomplete skip error", ctrl_err, 1);
        chk("R5 incomplete skip count", data_count, 6);
        clear_err();
        do_flush();

        // Flush without halt is rejected (R8).
        push_pkt(5, 32'h800, 32'h801);
        dump_set = 1'b1; cyc(); dump_set = 1'b0;
        chk("R8 flush not started", dump_busy, 0);
        chk("R8 flush error", ctrl_err, 1);
        cyc();
        chk("R8 data kept", data_count, 5);
        chk("R8 status kept", stat_count, 1);
        chk("R8 head kept", rd_data, 32'h800);
        clear_err();
        err_clr = 1'b1; dump_set = 1'b1; cyc(); err_clr = 1'b0; dump_set = 1'b0;
        chk("R10 error beats clear", ctrl_err, 1);
        clear_err();
        do_flush();

        // Skip while pushes and pop requests arrive (R6).
        push_pkt(9, 32'h900, 32'h9A);
        push_pkt(2, 32'hA00, 32'hAA);
        ffwd_set = 1'b1; wr_data_valid = 1'b1; wr_data = 32'hC00; cyc();
        ffwd_set = 1'b0; rd_data_pop = 1'b1; rd_stat_pop = 1'b1; wr_data = 32'hC01; cyc();
        wr_data = 32'hC02; wr_data_last = 1'b1; cyc();
        wr_data_valid = 1'b0; wr_data_last = 1'b0; cyc();
        rd_data_pop = 1'b0; rd_stat_pop = 1'b0;
        chk("R6 skip finished", ffwd_busy, 0);
        chk("R6 pushes kept, pops blocked", data_count, 5);
        chk("R6 status pops blocked", stat_count, 2);
        chk("R6 head after skip", rd_data, 32'hA00);
        for (int i = 0; i < 5; i++) begin
            chk("R1 drain order", rd_data, (i < 2) ? 32'hA00 + i : 32'hC00 + i - 2);
            pop_data();
        end
        chk("R1 drained empty", data_empty, 1);
        do_flush();

        // Fill to full; overflow dropped (R1, R2).
        for (int i = 0; i < 17; i++) begin
            wr_data_valid = 1'b1; wr_data = 32'hD00 + i; cyc();
        end
        wr_data_valid = 1'b0;
        chk("R1 full flag", data_full, 1);
        chk("R1 full count", data_count, 16);
        for (int i = 0; i < 16; i++) begin
            chk("R1 full drain order", rd_data, 32'hD00 + i);
            pop_data();
        end
        chk("R1 empty after drain", data_empty, 1);
        for (int i = 0; i < 5; i++) begin
            wr_stat_valid = 1'b1; wr_stat = 32'hE00 + i; cyc();
        end
        wr_stat_valid = 1'b0;
        chk("R2 status full", stat_full, 1);
        chk("R2 status full count", stat_count, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R2 status drain order", rd_stat, 32'hE00 + i);
            rd_stat_pop = 1'b1; cyc(); rd_stat_pop = 1'b0;
        end
        chk("R2 status empty", stat_empty, 1);
        do_flush();

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule